// File: doc/BRIEF.md
# Serial Flash Write-Enable Guard

This block sits at the command front end of a serial flash slave that speaks SPI mode 0. It brings chip-select, SCK and MOSI into the core clock domain and assembles the opcode from the first eight clock edges of each frame. It also keeps count of every SCK rising edge inside the frame. When chip-select rises, it decides whether the framed command may run. It emits a one-cycle execute strobe and a class code for each command it accepts.

The block holds the write-enable latch, which the status path reads back. It also holds a busy flag that covers array operations in progress and a deep power-down flag. A command that changes stored data is allowed to run only under four conditions:
- the latch is set,
- the frame carried a whole number of bytes,
- the power-up wait has finished and the supply is in spec,
- the device is neither busy nor powered down.

The array engine reports the end of each operation on a completion input. That completion clears the latch.

Top module: `wg_guard`

## Requirements
- R1: After rst_ni is asserted, wel_o, busy_o, dpd_o and exec_o are all 0.
- R2: A frame whose first byte is 0x06 sets wel_o and strobes exec_o with class 1, if the power-up wait is over and pwr_ok_i is 1.
- R3: Opcodes 0x01 (class 3), 0xE5 (4), 0x42 (5), 0x02 (6), 0xA2 (7), 0x20 (8), 0xD8 (9) and 0xC7 (10) modify data. One of them is accepted only while wel_o is 1. On acceptance it strobes exec_o with its class and sets busy_o. When wel_o is 0 the opcode is ignored.
- R4: A data-modifying frame whose count of SCK rising edges is not a multiple of 8 is ignored, and wel_o is left unchanged.
- R5: A done_i pulse while busy_o is 1 clears both busy_o and wel_o. While busy_o is 0, done_i has no effect.
- R6: A frame starting with 0x04 clears wel_o and strobes exec_o with class 2.
- R7: For PWRUP_CYCLES clock cycles after reset release, and at any time pwr_ok_i is 0, opcode 0x06 and the data-modifying opcodes are ignored.
- R8: Opcode 0xB9 sets dpd_o (class 11). While dpd_o is 1, only 0xAB is decoded. 0xAB clears dpd_o (class 12). Every other opcode is ignored while dpd_o is 1.
- R9: Every frame that ends while busy_o is 1 is ignored.
- R10: A frame with fewer than 8 SCK rising edges is ignored.
- R11: The opcode is sampled MSB first on rising SCK. Only the first 8 bits form the opcode, and later bits do not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| spi_cs_ni | input | 1 | SPI chip-select, active low |
| spi_sck_i | input | 1 | SPI serial clock, idle low |
| spi_mosi_i | input | 1 | SPI serial data in |
| pwr_ok_i | input | 1 | Supply within operating range |
| done_i | input | 1 | Array operation completion pulse |
| exec_o | output | 1 | One-cycle strobe for an accepted command |
| cmd_class_o | output | 4 | Class of the last accepted command |
| wel_o | output | 1 | Write-enable latch, readable as a status bit |
| busy_o | output | 1 | Array operation in progress |
| dpd_o | output | 1 | Deep power-down active |

## Verification
The hardest state to reach from the ports needs several conditions at once. The latch must be set, the device must be neither busy nor powered down, and a modifying frame must end with a bit count that is one to seven edges past a byte boundary. Only in that state does the multiple-of-eight rule alone decide the outcome. The random stimulus weights write-enable opcodes heavily, picks frame lengths from four bands that include misaligned multi-byte lengths, and issues completion pulses and supply dropouts only now and then. As a result, the latch is often set while misaligned modifying frames arrive. Directed frames also cover the power-up window, a bit-reversed opcode, and each deep power-down transition.

// File: rtl/wg_pkg.sv
package wg_pkg;
  typedef enum logic [3:0] {
    CLS_NONE    = 4'd0,
    CLS_WREN    = 4'd1,
    CLS_WRDI    = 4'd2,
    CLS_WRSR    = 4'd3,
    CLS_WRLOCK  = 4'd4,
    CLS_OTP     = 4'd5,
    CLS_PROG    = 4'd6,
    CLS_DPROG   = 4'd7,
    CLS_SUBERS  = 4'd8,
    CLS_SECERS  = 4'd9,
    CLS_BULKERS = 4'd10,
    CLS_SLEEP   = 4'd11,
    CLS_WAKE    = 4'd12
  } cmd_class_e;

  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_WRDI    = 8'h04;
  localparam logic [7:0] OP_WRSR    = 8'h01;
  localparam logic [7:0] OP_WRLOCK  = 8'hE5;
  localparam logic [7:0] OP_OTP     = 8'h42;
  localparam logic [7:0] OP_PROG    = 8'h02;
  localparam logic [7:0] OP_DPROG   = 8'hA2;
  localparam logic [7:0] OP_SUBERS  = 8'h20;
  localparam logic [7:0] OP_SECERS  = 8'hD8;
  localparam logic [7:0] OP_BULKERS = 8'hC7;
  localparam logic [7:0] OP_SLEEP   = 8'hB9;
  localparam logic [7:0] OP_WAKE    = 8'hAB;

  function automatic logic is_modify(cmd_class_e c);
    return (c >= CLS_WRSR) && (c <= CLS_BULKERS);
  endfunction
endpackage

// File: rtl/wg_spi_frontend.sv
module wg_spi_frontend #(
  parameter int SYNC_STAGES = 2,
  parameter int OP_BITS     = 8   // power of two: edge count wraps on it
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sck_i,
  input  logic               mosi_i,
  output logic               frame_end_o,
  output logic               op_valid_o,
  output logic               aligned_o,
  output logic [OP_BITS-1:0] op_o
);
  localparam int CNT_W = $clog2(OP_BITS);

  logic [SYNC_STAGES-1:0] cs_sync, sck_sync, mosi_sync;
  logic cs_d, sck_d;
  logic cs_s, sck_s, mosi_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_sync   <= '1;
      sck_sync  <= '0;
      mosi_sync <= '0;
      cs_d      <= 1'b1;
      sck_d     <= 1'b0;
    end else begin
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_ni};
      sck_sync  <= {sck_sync[SYNC_STAGES-2:0], sck_i};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi_i};
      cs_d      <= cs_s;
      sck_d     <= sck_s;
    end
  end

  assign cs_s   = cs_sync[SYNC_STAGES-1];
  assign sck_s  = sck_sync[SYNC_STAGES-1];
  assign mosi_s = mosi_sync[SYNC_STAGES-1];

  logic sck_rise;
  assign sck_rise    = sck_s & ~sck_d & ~cs_s;
  assign frame_end_o = cs_s & ~cs_d;

  // Edge count modulo OP_BITS plus a sticky "first byte complete" flag
  logic [CNT_W-1:0]   edge_cnt;
  logic               have_op;
  logic [OP_BITS-1:0] shreg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_cnt <= '0;
      have_op  <= 1'b0;
      shreg    <= '0;
    end else if (cs_s) begin
      edge_cnt <= '0;
      have_op  <= 1'b0;
    end else if (sck_rise) begin
      edge_cnt <= edge_cnt + 1'b1;
      if (!have_op) begin
        shreg <= {shreg[OP_BITS-2:0], mosi_s};
        if (edge_cnt == CNT_W'(OP_BITS-1)) have_op <= 1'b1;
      end
    end
  end

  assign op_valid_o = have_op;
  assign aligned_o  = (edge_cnt == '0);
  assign op_o       = shreg;

  p_op_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    have_op && !cs_s |=> $stable(shreg));
endmodule

// File: rtl/wg_decode.sv
module wg_decode
  import wg_pkg::*;
(
  input  logic [7:0] op_i,
  input  logic       sleep_i,
  output cmd_class_e cls_o
);
  always_comb begin
    cls_o = CLS_NONE;
    if (sleep_i) begin
      if (op_i == OP_WAKE) cls_o = CLS_WAKE;
    end else begin
      unique case (op_i)
        OP_WREN:    cls_o = CLS_WREN;
        OP_WRDI:    cls_o = CLS_WRDI;
        OP_WRSR:    cls_o = CLS_WRSR;
        OP_WRLOCK:  cls_o = CLS_WRLOCK;
        OP_OTP:     cls_o = CLS_OTP;
        OP_PROG:    cls_o = CLS_PROG;
        OP_DPROG:   cls_o = CLS_DPROG;
        OP_SUBERS:  cls_o = CLS_SUBERS;
        OP_SECERS:  cls_o = CLS_SECERS;
        OP_BULKERS: cls_o = CLS_BULKERS;
        OP_SLEEP:   cls_o = CLS_SLEEP;
        OP_WAKE:    cls_o = CLS_WAKE;
        default:    cls_o = CLS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/wg_pwrup_timer.sv
module wg_pwrup_timer #(
  parameter int PWRUP_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int TW = $clog2(PWRUP_CYCLES + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt <= '0;
    else if (cnt != TW'(PWRUP_CYCLES))    cnt <= cnt + 1'b1;
  end

  assign done_o = (cnt == TW'(PWRUP_CYCLES));

  p_timer_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
endmodule

// File: rtl/wg_guard.sv
module wg_guard
  import wg_pkg::*;
#(
  parameter int PWRUP_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2,
  parameter int OP_BITS      = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       spi_cs_ni,
  input  logic       spi_sck_i,
  input  logic       spi_mosi_i,
  input  logic       pwr_ok_i,
  input  logic       done_i,
  output logic       exec_o,
  output logic [3:0] cmd_class_o,
  output logic       wel_o,
  output logic       busy_o,
  output logic       dpd_o
);
  logic               frame_end, op_valid, aligned, timer_done;
  logic [OP_BITS-1:0] op;
  cmd_class_e         cls;

  wg_spi_frontend #(.SYNC_STAGES(SYNC_STAGES), .OP_BITS(OP_BITS)) u_fe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (spi_cs_ni),
    .sck_i      (spi_sck_i),
    .mosi_i     (spi_mosi_i),
    .frame_end_o(frame_end),
    .op_valid_o (op_valid),
    .aligned_o  (aligned),
    .op_o       (op)
  );

  logic wel_q, busy_q, dpd_q, exec_q;
  cmd_class_e cls_q;

  wg_decode u_dec (
    .op_i   (op[7:0]),
    .sleep_i(dpd_q),
    .cls_o  (cls)
  );

  wg_pwrup_timer #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_o(timer_done)
  );

  logic ready, accept;
  assign ready = timer_done & pwr_ok_i;

  always_comb begin
    accept = 1'b0;
    if (frame_end && op_valid && !busy_q) begin
      unique case (cls)
        CLS_NONE:                        accept = 1'b0;
        CLS_WREN:                        accept = ready;
        CLS_WRDI, CLS_SLEEP, CLS_WAKE:   accept = 1'b1;
        default:                         accept = ready & wel_q & aligned;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      busy_q <= 1'b0;
      dpd_q  <= 1'b0;
      exec_q <= 1'b0;
      cls_q  <= CLS_NONE;
    end else begin
      exec_q <= accept;
      if (accept) begin
        cls_q <= cls;
        unique case (cls)
          CLS_WREN:  wel_q  <= 1'b1;
          CLS_WRDI:  wel_q  <= 1'b0;
          CLS_SLEEP: dpd_q  <= 1'b1;
          CLS_WAKE:  dpd_q  <= 1'b0;
          default:   busy_q <= 1'b1;
        endcase
      end else if (done_i && busy_q) begin
        busy_q <= 1'b0;
        wel_q  <= 1'b0;
      end
    end
  end

  assign exec_o      = exec_q;
  assign cmd_class_o = cls_q;
  assign wel_o       = wel_q;
  assign busy_o      = busy_q;
  assign dpd_o       = dpd_q;

  p_wel_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_o) |-> exec_o && cmd_class_o == CLS_WREN);
  p_mod_needs_wel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o && is_modify(cmd_class_e'(cmd_class_o)) |-> $past(wel_q));
  p_mod_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o && is_modify(cmd_class_e'(cmd_class_o)) |-> $past(aligned));
  p_done_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && busy_q |=> !wel_q && !busy_q);
  p_mod_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o && is_modify(cmd_class_e'(cmd_class_o)) |-> $past(ready));
  p_sleep_filter_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o && $past(dpd_q) |-> cmd_class_o == CLS_WAKE);
  p_busy_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> !$past(busy_q));
  p_short_frame_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end && !op_valid |=> !exec_o);
  p_exec_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> !exec_o);
endmodule

// File: tb/wg_guard_test.sv
module wg_guard_test;
  localparam int PWRUP = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, pwr_ok = 1'b1, done = 1'b0;
  logic exec;
  logic [3:0] cls;
  logic wel, busy, dpd;

  always #2 clk = ~clk;

  wg_guard #(.PWRUP_CYCLES(PWRUP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .spi_cs_ni(cs_n), .spi_sck_i(sck),
    .spi_mosi_i(mosi), .pwr_ok_i(pwr_ok), .done_i(done), .exec_o(exec),
    .cmd_class_o(cls), .wel_o(wel), .busy_o(busy), .dpd_o(dpd)
  );

  int n_chk = 0, n_bad = 0;
  int exec_cnt = 0;
  int last_cls = 0;
  int cyc = 0;
  bit finished = 0;
  bit m_wel = 0, m_busy = 0, m_dpd = 0, m_ready = 0;

  always @(negedge clk) begin
    if (exec) begin
      exec_cnt++;
      last_cls = int'(cls);
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int ref_class(logic [7:0] op, bit sleeping);
    if (sleeping) return (op == 8'hAB) ? 12 : 0;
    case (op)
      8'h06: return 1;  8'h04: return 2;  8'h01: return 3;  8'hE5: return 4;
      8'h42: return 5;  8'h02: return 6;  8'hA2: return 7;  8'h20: return 8;
      8'hD8: return 9;  8'hC7: return 10; 8'hB9: return 11; 8'hAB: return 12;
      default: return 0;
    endcase
  endfunction

  task automatic send(logic [7:0] op, int nb);
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      mosi = (i < 8) ? op[7-i] : 1'($urandom);
      repeat (3) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic frame(logic [7:0] op, int nb, string tag);
    int c;
    int exp_exec = 0;
    c = ref_class(op, m_dpd);
    if (nb >= 8 && !m_busy) begin
      case (c)
        0: ;
        1: if (m_ready) begin exp_exec = 1; m_wel = 1; end
        2: begin exp_exec = 1; m_wel = 0; end
        11: begin exp_exec = 1; m_dpd = 1; end
        12: begin exp_exec = 1; m_dpd = 0; end
        default: if (m_ready && m_wel && (nb % 8 == 0)) begin exp_exec = 1; m_busy = 1; end
      endcase
    end
    exec_cnt = 0;
    send(op, nb);
    check(tag, "exec count", exec_cnt, exp_exec);
    if (exp_exec == 1) check(tag, "class", last_cls, c);
    check(tag, "wel", int'(wel), int'(m_wel));
    check(tag, "busy", int'(busy), int'(m_busy));
    check(tag, "dpd", int'(dpd), int'(m_dpd));
  endtask

  task automatic pulse_done(string tag);
    @(negedge clk) done = 1'b1;
    @(negedge clk) done = 1'b0;
    if (m_busy) begin m_busy = 0; m_wel = 0; end
    repeat (2) @(negedge clk);
    check(tag, "wel after done", int'(wel), int'(m_wel));
    check(tag, "busy after done", int'(busy), int'(m_busy));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 190000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  localparam logic [7:0] OPS [14] = '{8'h06, 8'h04, 8'h01, 8'hE5, 8'h42, 8'h02, 8'hA2,
                                      8'h20, 8'hD8, 8'hC7, 8'hB9, 8'hAB, 8'h06, 8'h05};

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1", "wel at reset", int'(wel), 0);
    check("R1", "busy at reset", int'(busy), 0);
    check("R1", "dpd at reset", int'(dpd), 0);
    check("R1", "exec at reset", int'(exec), 0);
    rst_n = 1'b1;
    m_ready = 0;
    frame(8'h06, 8, "R7 power-up wait");
    repeat (PWRUP) @(negedge clk);
    m_ready = 1;
    pwr_ok = 1'b0; m_ready = 0;
    frame(8'h06, 8, "R7 supply low");
    pwr_ok = 1'b1; m_ready = 1;
    frame(8'h02, 32, "R3 no latch");
    frame(8'h06, 8, "R2 set latch");
    frame(8'h04, 5, "R10 short frame");
    frame(8'hD8, 33, "R4 misaligned");
    frame(8'hD8, 32, "R3 accepted erase");
    frame(8'h04, 8, "R9 busy ignores");
    pulse_done("R5 completion");
    pulse_done("R5 idle done");
    frame(8'h06, 8, "R2 set again");
    frame(8'h04, 8, "R6 disable");
    frame(8'h60, 8, "R11 reversed opcode");
    frame(8'h06, 16, "R11 trailing bits");
    frame(8'hB9, 8, "R8 enter sleep");
    frame(8'h04, 8, "R8 sleep ignores");
    frame(8'hC7, 8, "R8 sleep blocks modify");
    frame(8'hAB, 8, "R8 wake");
    frame(8'hC7, 8, "R3 bulk erase");
    pulse_done("R5 bulk done");

    for (int k = 0; k < 300; k++) begin
      logic [7:0] op;
      int nb;
      int band;
      op = ($urandom % 10 == 0) ? 8'($urandom) : OPS[$urandom % 14];
      band = $urandom % 4;
      case (band)
        0: nb = $urandom % 8;
        1: nb = 8 * (1 + $urandom % 4);
        2: nb = 8 * (1 + $urandom % 3) + 1 + $urandom % 7;
        default: nb = 8;
      endcase
      frame(op, nb, "R3/R4 random");
      if (m_busy && ($urandom % 10 < 4)) pulse_done("R5 random");
      else if ($urandom % 20 == 0) pulse_done("R5 random idle");
      if ($urandom % 25 == 0) begin
        pwr_ok = ~pwr_ok;
        m_ready = pwr_ok;
      end
    end

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule